// File: doc/BRIEF.md
# Unaligned Load/Store Lane Aligner

This block connects a 64-bit integer pipeline to a byte-addressed memory. The memory's data port is one doubleword wide and is addressed on doubleword boundaries. The pipeline hands it one load or store at a time, of byte, halfword, word or doubleword size, at any byte address. The block turns the request into memory beats. Each beat carries a doubleword-aligned address, a byte-enable mask and store data already moved onto the right byte lanes. For a load, the block gathers the returned lanes back into a right-justified 64-bit value. That value is sign- or zero-extended according to a flag in the request.

Data is little-endian: byte k of a value sits at byte address addr+k. No alignment is needed. An access whose bytes run past the end of a doubleword is split into two beats, the lower doubleword first and the next one second. The bytes from the first beat are held in a register until the second beat returns and the two halves are merged. Requests, memory beats and responses each use a valid/ready handshake. Memory acknowledges every beat, load or store, with a one-cycle return strobe.

Top module: `lsu_align`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, req_ready is 1, mem_valid is 0 and rsp_valid is 0.
- R2: Every beat address is the access address with its low three bits cleared, plus 8 for a second beat. Byte k of the value travels on lane (addr+k) mod 8 of the beat that covers byte address addr+k.
- R3: req_size encodes 0 = byte, 1 = halfword, 2 = word, 3 = doubleword, so n = 1, 2, 4 or 8 bytes. The lane mask is ((1<<n)-1) shifted left by addr mod 8. Its bits 7..0 are the first beat's mem_be and its bits 15..8 are the second beat's mem_be. This holds for loads and stores alike, so a store changes no memory byte outside the n addressed ones.
- R4: When (addr mod 8) + n exceeds 8, exactly two beats are issued, the second only after the first has returned. Otherwise exactly one beat is issued.
- R5: A load with req_unsigned = 0 and n < 8 returns the n bytes with bits 63..8n copied from bit 8n-1.
- R6: A load with req_unsigned = 1 and n < 8 returns the n bytes with bits 63..8n cleared.
- R7: A doubleword load returns all 64 bits unchanged whatever req_unsigned is, and a doubleword store writes all 64 bits.
- R8: rsp_valid rises only after the final beat's return strobe, never while a beat is pending. For a split load it carries the bytes of both beats merged. For a store it carries zero.
- R9: Only one access is outstanding. req_ready is 0 from the cycle after a request is taken until the response has been accepted.
- R10: Once raised, mem_valid keeps mem_addr, mem_be, mem_wdata and mem_write stable until mem_ready is seen. Once raised, rsp_valid keeps rsp_data stable until rsp_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_unsigned | input | 1 | Zero-extend a load instead of sign-extending it |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | XLEN | Store value, right-justified |
| mem_valid | output | 1 | Memory beat present |
| mem_ready | input | 1 | Memory takes the beat |
| mem_write | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Doubleword-aligned beat address |
| mem_be | output | XLEN/8 | Byte-lane enables of the beat |
| mem_wdata | output | XLEN | Lane-aligned write data |
| mem_rvalid | input | 1 | Beat return strobe from memory |
| mem_rdata | input | XLEN | Read data of the returned beat |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Pipeline takes the response |
| rsp_data | output | XLEN | Extended load result, zero for stores |

## Verification
The hardest case to reach is a split access whose second beat is delayed: the memory must stall the handshake on a beat while the first beat's bytes wait in the holding register. The bench sweeps every size at every offset within a doubleword, so each split combination occurs. It drives a memory model whose ready signal is low one cycle in three, so both beats of a split access meet stalls at varying phases. The load sweep fills memory with both high-bit-set and high-bit-clear patterns, so the extension byte of a split result comes from a byte that arrived in the second beat.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
  import lsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [$clog2(XLEN/8)-1:0] off,
  input  acc_size_e                 size,
  input  logic [XLEN-1:0]           wdata,
  output logic [XLEN/8-1:0]         be_lo,
  output logic [XLEN/8-1:0]         be_hi,
  output logic [XLEN-1:0]           wd_lo,
  output logic [XLEN-1:0]           wd_hi,
  output logic                      split
);
  localparam int NB    = XLEN / 8;
  localparam int OFF_W = $clog2(NB);

  logic [OFF_W:0]     nbytes;
  logic [2*NB-1:0]    base_mask;
  logic [2*NB-1:0]    wide_mask;
  logic [2*XLEN-1:0]  wide_data;

  assign nbytes = (OFF_W+1)'(1) << size;

  // one enable per byte of the access, before shifting onto lanes
  for (genvar g = 0; g < 2*NB; g++) begin : g_base
    assign base_mask[g] = (g < int'(nbytes));
  end

  assign wide_mask = base_mask << off;
  assign wide_data = {{XLEN{1'b0}}, wdata} << {off, 3'b000};

  assign be_lo = wide_mask[NB-1:0];
  assign be_hi = wide_mask[2*NB-1:NB];
  assign wd_lo = wide_data[XLEN-1:0];
  assign wd_hi = wide_data[2*XLEN-1:XLEN];
  assign split = |be_hi;

endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
  import lsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2*XLEN-1:0]         raw,
  input  logic [$clog2(XLEN/8)-1:0] off,
  input  acc_size_e                 size,
  input  logic                      uns,
  output logic [XLEN-1:0]           result
);
  localparam int NB    = XLEN / 8;
  localparam int OFF_W = $clog2(NB);

  logic [XLEN-1:0] low;
  logic [OFF_W:0]  nbytes;
  logic            sign_bit;
  logic            fill;

  assign low    = XLEN'(raw >> {off, 3'b000});
  assign nbytes = (OFF_W+1)'(1) << size;

  always_comb begin
    case (size)
      SZ_BYTE: sign_bit = low[7];
      SZ_HALF: sign_bit = low[15];
      SZ_WORD: sign_bit = low[31];
      default: sign_bit = 1'b0;
    endcase
  end

  assign fill = sign_bit & ~uns;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign result[8*g +: 8] = ((OFF_W+1)'(g) < nbytes) ? low[8*g +: 8] : {8{fill}};
  end

endmodule

// File: rtl/lsu_beat_ctrl.sv
module lsu_beat_ctrl
  import lsu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_fire,
  input  logic split,
  input  logic mem_accept,
  input  logic mem_rvalid,
  input  logic rsp_fire,
  output logic idle,
  output logic first_ret,
  output logic last_ret,
  output logic beat_q
);
  seq_state_e st_q;
  logic       in_wait;

  assign idle      = (st_q == ST_IDLE);
  assign in_wait   = (st_q == ST_WAIT) && mem_rvalid;
  assign first_ret = in_wait && split && !beat_q;
  assign last_ret  = in_wait && !(split && !beat_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      beat_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE:  if (req_fire) st_q <= ST_ISSUE;
        ST_ISSUE: if (mem_accept) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (first_ret) begin
            st_q   <= ST_ISSUE;
            beat_q <= 1'b1;
          end else if (last_ret) begin
            st_q <= ST_RESP;
          end
        end
        default: if (rsp_fire) begin
          st_q   <= ST_IDLE;
          beat_q <= 1'b0;
        end
      endcase
    end
  end

  // R4: a second beat exists only for a split access
  a_r4_second_beat_split: assert property (@(posedge clk) disable iff (rst)
    beat_q |-> split);

  // R8: the final return hands over to the response, not another beat
  a_r8_last_to_resp: assert property (@(posedge clk) disable iff (rst)
    last_ret |=> !idle && !(mem_rvalid && first_ret));

endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [XLEN-1:0]   req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [XLEN/8-1:0] mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_rvalid,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [XLEN-1:0]   rsp_data
);
  localparam int NB    = XLEN / 8;
  localparam int OFF_W = $clog2(NB);

  logic             idle, first_ret, last_ret, beat_q;
  logic             req_fire, mem_accept, rsp_fire;
  logic [NB-1:0]    be_lo, be_hi;
  logic [XLEN-1:0]  wd_lo, wd_hi;
  logic             split_now;
  logic [XLEN-1:0]  ext_result;
  logic [2*XLEN-1:0] ld_raw;

  logic              r_write, r_uns, r_split;
  acc_size_e         r_size;
  logic [OFF_W-1:0]  r_off;
  logic [ADDR_W-1:0] r_base;
  logic [NB-1:0]     r_be_hi;
  logic [XLEN-1:0]   r_wd_hi;
  logic [XLEN-1:0]   r_lo_data;

  assign req_ready  = idle;
  assign req_fire   = req_valid && idle;
  assign mem_accept = mem_valid && mem_ready;
  assign rsp_fire   = rsp_valid && rsp_ready;

  lsu_lane_map #(.XLEN(XLEN)) u_lane_map (
    .off   (req_addr[OFF_W-1:0]),
    .size  (acc_size_e'(req_size)),
    .wdata (req_wdata),
    .be_lo (be_lo),
    .be_hi (be_hi),
    .wd_lo (wd_lo),
    .wd_hi (wd_hi),
    .split (split_now)
  );

  lsu_beat_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_fire   (req_fire),
    .split      (r_split),
    .mem_accept (mem_accept),
    .mem_rvalid (mem_rvalid),
    .rsp_fire   (rsp_fire),
    .idle       (idle),
    .first_ret  (first_ret),
    .last_ret   (last_ret),
    .beat_q     (beat_q)
  );

  assign ld_raw = r_split ? {mem_rdata, r_lo_data} : {{XLEN{1'b0}}, mem_rdata};

  lsu_load_ext #(.XLEN(XLEN)) u_load_ext (
    .raw    (ld_raw),
    .off    (r_off),
    .size   (r_size),
    .uns    (r_uns),
    .result (ext_result)
  );

  // request latch: fields needed after the first beat
  always_ff @(posedge clk) begin
    if (rst) begin
      r_write <= 1'b0;
      r_uns   <= 1'b0;
      r_split <= 1'b0;
      r_size  <= SZ_BYTE;
      r_off   <= '0;
      r_base  <= '0;
      r_be_hi <= '0;
      r_wd_hi <= '0;
    end else if (req_fire) begin
      r_write <= req_write;
      r_uns   <= req_unsigned;
      r_split <= split_now;
      r_size  <= acc_size_e'(req_size);
      r_off   <= req_addr[OFF_W-1:0];
      r_base  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      r_be_hi <= be_hi;
      r_wd_hi <= wd_hi;
    end
  end

  // lower-doubleword holding register for split loads
  always_ff @(posedge clk) begin
    if (rst) r_lo_data <= '0;
    else if (first_ret) r_lo_data <= mem_rdata;
  end

  // memory beat port
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
    end else if (req_fire) begin
      mem_valid <= 1'b1;
      mem_write <= req_write;
      mem_addr  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      mem_be    <= be_lo;
      mem_wdata <= wd_lo;
    end else if (first_ret) begin
      mem_valid <= 1'b1;
      mem_addr  <= r_base + ADDR_W'(NB);
      mem_be    <= r_be_hi;
      mem_wdata <= r_wd_hi;
    end else if (mem_accept) begin
      mem_valid <= 1'b0;
    end
  end

  // response port
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (last_ret) begin
      rsp_valid <= 1'b1;
      rsp_data  <= r_write ? '0 : ext_result;
    end else if (rsp_fire) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> req_ready && !mem_valid && !rsp_valid);

  a_r2_beat_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

  a_r3_lanes_enabled: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_be != '0));

  // R4: the spill-over beat always begins at lane 0
  a_r4_second_from_lane0: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && beat_q) |-> mem_be[0]);

  a_r8_no_rsp_with_beat: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_valid);

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    (mem_valid || rsp_valid) |-> !req_ready);

  a_r10_beat_held: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
      && $stable(mem_wdata) && $stable(mem_write));

  a_r10_rsp_held: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));

endmodule

// File: tb/lsu_align_tb.sv
`timescale 1ns/1ps
module lsu_align_tb;
  localparam int XLEN   = 64;
  localparam int ADDR_W = 32;
  localparam int NB     = XLEN / 8;
  localparam int MEMB   = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [1:0]        req_size = '0;
  logic              req_unsigned = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [XLEN-1:0]   req_wdata = '0;
  logic              mem_valid;
  logic              mem_ready = 1'b0;
  logic              mem_write;
  logic [ADDR_W-1:0] mem_addr;
  logic [NB-1:0]     mem_be;
  logic [XLEN-1:0]   mem_wdata;
  logic              mem_rvalid = 1'b0;
  logic [XLEN-1:0]   mem_rdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [XLEN-1:0]   rsp_data;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  lsu_align #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
    .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // memory model, acting at the falling edge
  logic [7:0]        tb_mem [MEMB];
  logic [7:0]        exp_mem[MEMB];
  int                nbeats = 0;
  logic [ADDR_W-1:0] log_addr[2];
  logic [NB-1:0]     log_be[2];
  logic              pend = 1'b0;
  logic [ADDR_W-1:0] p_addr;
  logic [NB-1:0]     p_be;
  logic [XLEN-1:0]   p_wdata;
  logic              p_write;
  int                cyc = 0;

  always @(negedge clk) begin
    if (rst) begin
      mem_ready  = 1'b0;
      mem_rvalid = 1'b0;
      pend       = 1'b0;
    end else begin
      mem_rvalid = 1'b0;
      if (pend) begin
        for (int k = 0; k < NB; k++) begin
          if (p_write && p_be[k]) tb_mem[(int'(p_addr) + k) % MEMB] = p_wdata[8*k +: 8];
          mem_rdata[8*k +: 8] = tb_mem[(int'(p_addr) + k) % MEMB];
        end
        if (nbeats < 2) begin
          log_addr[nbeats] = p_addr;
          log_be[nbeats]   = p_be;
        end
        nbeats     = nbeats + 1;
        mem_rvalid = 1'b1;
        pend       = 1'b0;
      end
      mem_ready = ((cyc % 3) != 1);
      cyc       = cyc + 1;
      if (mem_valid && mem_ready) begin
        pend    = 1'b1;
        p_addr  = mem_addr;
        p_be    = mem_be;
        p_wdata = mem_wdata;
        p_write = mem_write;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic uns,
                        input logic [ADDR_W-1:0] addr, input logic [XLEN-1:0] wd,
                        input int rdly, output logic [XLEN-1:0] rd);
    logic [XLEN-1:0] held;
    @(negedge clk);
    chk(req_ready, "R9", {63'd0, req_ready}, 64'd1);
    nbeats       = 0;
    req_valid    = 1'b1;
    req_write    = wr;
    req_size     = sz;
    req_unsigned = uns;
    req_addr     = addr;
    req_wdata    = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9", {63'd0, req_ready}, 64'd0);
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    for (int d = 0; d < rdly; d++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == held, "R10", rsp_data, held);
    end
    rd        = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    #(20ns * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] rd, wd, expv;
    logic [15:0]     mask;
    int              n, a, nexp, idx;
    idx = 0;
    for (int i = 0; i < MEMB; i++) tb_mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    chk(req_ready && !mem_valid && !rsp_valid, "R1", {61'd0, req_ready, mem_valid, rsp_valid}, 64'd4);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_valid && !rsp_valid, "R1", {61'd0, req_ready, mem_valid, rsp_valid}, 64'd4);

    // store sweep: every size at every offset
    for (int sz = 0; sz < 4; sz++) begin
      for (int off = 0; off < NB; off++) begin
        n  = 1 << sz;
        a  = 8 + off;
        wd = 64'hF1E2_D3C4_B5A6_9788 ^ {8{8'(sz * 8 + off)}};
        for (int i = 0; i < MEMB; i++) begin
          tb_mem[i]  = 8'(i * 37 + 5 + sz);
          exp_mem[i] = tb_mem[i];
        end
        for (int k = 0; k < n; k++) exp_mem[a + k] = wd[8*k +: 8];
        mask = 16'(((1 << n) - 1) << off);
        nexp = (off + n > 8) ? 2 : 1;
        access(1'b1, 2'(sz), 1'b0, ADDR_W'(a), wd, idx % 3, rd);
        idx++;
        chk(nbeats == nexp, "R4", 64'(nbeats), 64'(nexp));
        chk(log_addr[0] == 32'd8, "R2", 64'(log_addr[0]), 64'd8);
        chk(log_be[0] == mask[7:0], "R3", 64'(log_be[0]), 64'(mask[7:0]));
        if (nexp == 2) begin
          chk(log_addr[1] == 32'd16, "R4", 64'(log_addr[1]), 64'd16);
          chk(log_be[1] == mask[15:8], "R3", 64'(log_be[1]), 64'(mask[15:8]));
        end
        chk(rd == '0, "R8", rd, 64'd0);
        for (int i = 0; i < MEMB; i++)
          chk(tb_mem[i] == exp_mem[i], (sz == 3) ? "R7" : "R3", 64'(tb_mem[i]), 64'(exp_mem[i]));
      end
    end

    // load sweep: sizes, offsets, signedness, both sign polarities
    for (int pol = 0; pol < 2; pol++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int off = 0; off < NB; off++) begin
          for (int u = 0; u < 2; u++) begin
            n = 1 << sz;
            a = 8 + off;
            for (int i = 0; i < MEMB; i++)
              tb_mem[i] = pol ? (8'(i * 29 + 3) | 8'h80) : (8'(i * 29 + 3) & 8'h7F);
            expv = '0;
            for (int k = 0; k < n; k++) expv[8*k +: 8] = tb_mem[a + k];
            if (n < 8 && u == 0 && expv[8*n-1])
              for (int b = 8 * n; b < XLEN; b++) expv[b] = 1'b1;
            nexp = (off + n > 8) ? 2 : 1;
            access(1'b0, 2'(sz), u[0], ADDR_W'(a), 64'd0, idx % 3, rd);
            idx++;
            chk(nbeats == nexp, "R4", 64'(nbeats), 64'(nexp));
            if (sz == 3)          chk(rd == expv, "R7", rd, expv);
            else if (u == 1)      chk(rd == expv, "R6", rd, expv);
            else                  chk(rd == expv, "R5", rd, expv);
            if (nexp == 2)        chk(rd == expv, "R8", rd, expv);
            chk(log_addr[0] == 32'd8, "R2", 64'(log_addr[0]), 64'd8);
          end
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule